// File: doc/BRIEF.md
# Block-Bypass Binary Adder

This block adds two unsigned words and an incoming carry, producing a word-wide sum and an outgoing carry. The word is cut into equal slices. Inside each slice the bits ripple their carries from one full-adder cell to the next. Alongside the ripple, each slice ANDs its per-bit propagate terms (`a ^ b`) into one slice-wide propagate flag.

When that flag is set, every bit of the slice would only pass an incoming carry along. A two-way selector therefore hands the slice's carry-in straight to its carry-out and skips the ripple path. When the flag is clear, the selector takes the rippled carry. A long carry chain through propagating slices thus costs one selector per slice rather than one cell per bit.

The block is purely combinational and has no clock or reset. It is meant to be dropped into a datapath where the sum is captured by the surrounding registers. The word width must be a whole multiple of the slice width. The defaults are a 16-bit word and 4-bit slices.

Top module: `bypass_adder`

## Requirements
- R1: For every input pattern, `{carry_out, sum_out}` equals `op_a + op_b + carry_in` taken as a (WIDTH+1)-bit unsigned value.
- R2: A slice's propagate flag is set exactly when every bit position i of that slice has `op_a[i] != op_b[i]`. Slice k covers bits `[k*SLICE +: SLICE]`, with slice 0 at the least significant end.
- R3: While a slice's propagate flag is set, that slice's carry-out equals its carry-in. The slice then contributes sum bits equal to the inverted carry-in.
- R4: While a slice's propagate flag is clear, that slice's carry-out equals the carry out of its own ripple chain, which depends only on the slice's operand bits and carry-in.
- R5: With `op_a == ~op_b` over the full word, `sum_out` is all ones when `carry_in` is 0 and all zeros when `carry_in` is 1, and `carry_out` equals `carry_in`.
- R6: With `op_a` all ones, `op_b` zero and `carry_in` 1, `sum_out` is zero and `carry_out` is 1.
- R7: A carry generated in slice 0 reaches the word's carry-out through every higher slice that is in full propagate.
- R8: A WIDTH that is not a whole multiple of SLICE is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Incoming carry, weight 1 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
Every result of this block is combinational, so `sum_out` and `carry_out` settle in the same cycle as the operands that produce them, with zero register stages. The bench applies each operand set just after a rising clock edge and samples on the following falling edge, half a period later. By then the slice selectors and ripple chains have settled, and no sample lands on an edge where inputs change. Expected values come from a plain wide addition in the bench and from hand-worked patterns for the propagate and skip cases.

// File: rtl/bypass_adder_pkg.sv
package bypass_adder_pkg;
  // Slice count for a given word and slice width.
  function automatic int unsigned slice_count(input int unsigned width, input int unsigned slice);
    return width / slice;
  endfunction

  // True when the word divides evenly into slices.
  function automatic bit slices_fit(input int unsigned width, input int unsigned slice);
    return (slice != 0) && ((width % slice) == 0);
  endfunction
endpackage

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned SLICE = 4
) (
  input  logic [SLICE-1:0] x,
  input  logic [SLICE-1:0] y,
  input  logic             ci,
  output logic [SLICE-1:0] s,
  output logic             co
);
  logic [SLICE:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < SLICE; i++) begin : g_cell
    logic h;
    assign h      = x[i] ^ y[i];
    assign s[i]   = h ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (h & c[i]);
  end

  assign co = c[SLICE];

  // R1 at slice level: ripple result matches arithmetic addition
  always_comb begin
    p_ripple_sum_r1: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{SLICE{1'b0}}, ci}))
      else $error("ripple chain sum mismatch");
  end
endmodule

// File: rtl/slice_propagate.sv
module slice_propagate #(
  parameter int unsigned SLICE = 4
) (
  input  logic [SLICE-1:0] x,
  input  logic [SLICE-1:0] y,
  output logic             grp_p
);
  logic [SLICE-1:0] bit_p;

  assign bit_p = x ^ y;
  assign grp_p = &bit_p;

  // R2: a set flag means the operands add to all ones without carry
  always_comb begin
    p_group_prop_r2: assert (!grp_p || ((x + y) == {SLICE{1'b1}}))
      else $error("propagate flag set while operands do not complement");
  end
endmodule

// File: rtl/skip_slice.sv
module skip_slice #(
  parameter int unsigned SLICE = 4
) (
  input  logic [SLICE-1:0] x,
  input  logic [SLICE-1:0] y,
  input  logic             ci,
  output logic [SLICE-1:0] s,
  output logic             co
);
  logic rip_co;
  logic grp_p;

  ripple_chain #(.SLICE(SLICE)) u_rip (
    .x  (x),
    .y  (y),
    .ci (ci),
    .s  (s),
    .co (rip_co)
  );

  slice_propagate #(.SLICE(SLICE)) u_prop (
    .x     (x),
    .y     (y),
    .grp_p (grp_p)
  );

  // Skip selector: bypass the ripple when the whole slice propagates.
  always_comb begin
    if (grp_p) co = ci;
    else       co = rip_co;
  end

  always_comb begin
    // R3: in propagate, the ripple path itself agrees with the bypass
    p_skip_agree_r3: assert (!grp_p || (rip_co == ci))
      else $error("ripple carry disagrees with bypassed carry");
    // R3: in propagate, sum bits are the inverted carry-in
    p_skip_sum_r3: assert (!grp_p || (s == {SLICE{~ci}}))
      else $error("propagate slice sum wrong");
    // R4: slice carry-out matches arithmetic carry of the slice
    p_slice_carry_r4: assert (co == (({1'b0, x} + {1'b0, y} + {{SLICE{1'b0}}, ci}) >> SLICE))
      else $error("slice carry-out mismatch");
  end
endmodule

// File: rtl/bypass_adder.sv
module bypass_adder
  import bypass_adder_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SLICE = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int unsigned NSLICE = slice_count(WIDTH, SLICE);

  // R8: word must divide evenly into slices
  if (!slices_fit(WIDTH, SLICE)) begin : g_bad_width_r8
    $error("WIDTH must be a whole multiple of SLICE");
  end

  logic [NSLICE:0] chain;

  assign chain[0] = carry_in;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    skip_slice #(.SLICE(SLICE)) u_slice (
      .x  (op_a[k*SLICE +: SLICE]),
      .y  (op_b[k*SLICE +: SLICE]),
      .ci (chain[k]),
      .s  (sum_out[k*SLICE +: SLICE]),
      .co (chain[k+1])
    );
  end

  assign carry_out = chain[NSLICE];

  always_comb begin
    // R1: whole-word result equals arithmetic addition
    p_word_sum_r1: assert ({carry_out, sum_out} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("word sum mismatch");
    // R5: full-word complement operands pass the carry straight through
    p_full_prop_r5: assert ((op_a != ~op_b) || (carry_out == carry_in))
      else $error("full propagate carry-out mismatch");
  end
endmodule

// File: tb/tb_bypass_adder.sv
module tb_bypass_adder;
  localparam int unsigned W = 16;
  localparam int unsigned S = 4;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         carry_in;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int tests_run;
  int tests_failed;
  bit done;

  bypass_adder #(.WIDTH(W), .SLICE(S)) dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Drive after a rising edge, sample on the next falling edge.
  task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic ci, input string req);
    logic [W:0] exp;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    @(negedge clk);
    tests_run++;
    if ({carry_out, sum_out} !== exp) begin
      tests_failed++;
      $display("FAIL %s: a=%h b=%h ci=%0d got {co,sum}=%h exp=%h",
               req, a, b, ci, {carry_out, sum_out}, exp);
    end
  endtask

  task automatic t_reset_state();
    // R1: all-zero inputs give zero result
    apply_check('0, '0, 1'b0, "R1 reset-state zero");
  endtask

  task automatic t_full_propagate();
    // R5: complement operands, both carry-in values
    apply_check(16'hA5C3, ~16'hA5C3, 1'b0, "R5 complement ci=0");
    apply_check(16'hA5C3, ~16'hA5C3, 1'b1, "R5 complement ci=1");
    apply_check(16'h0000, 16'hFFFF, 1'b1, "R5 zero/ones ci=1");
  endtask

  task automatic t_one_slice_propagate();
    // R2/R3: slice 1 (bits 7:4) in full propagate, carry from slice 0 skips it
    apply_check(16'h00A8, 16'h0058, 1'b0, "R3 slice1 bypass carry");
    // R2: slice 1 has one non-propagate bit, flag clear
    apply_check(16'h00B8, 16'h0058, 1'b0, "R2 slice1 flag clear");
  endtask

  task automatic t_ripple_path();
    // R4: slices not in propagate, carries from generate bits
    apply_check(16'h0F0F, 16'h0101, 1'b0, "R4 generate in slices");
    apply_check(16'h8000, 16'h8000, 1'b0, "R4 top generate");
    apply_check(16'h1234, 16'h0000, 1'b1, "R4 kill chain");
  endtask

  task automatic t_full_carry();
    // R6: all ones plus carry-in wraps to zero with carry-out
    apply_check(16'hFFFF, 16'h0000, 1'b1, "R6 wrap through all slices");
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R6 max operands");
  endtask

  task automatic t_long_skip();
    // R7: slice 0 generates, slices 1..3 propagate, carry exits the word
    apply_check(16'hF0F8, 16'h0F08, 1'b0, "R7 carry skips three slices");
    apply_check(16'h5A58, 16'hA5A8, 1'b0, "R7 mixed propagate skip");
  endtask

  task automatic t_random();
    // R1: random operands
    for (int i = 0; i < 200; i++) begin
      apply_check(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end
  endtask

  initial begin
    done = 1'b0;
    tests_run = 0;
    tests_failed = 0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R8 concerns elaboration; the default WIDTH/SLICE pair is valid here.
    t_reset_state();
    t_full_propagate();
    t_one_slice_propagate();
    t_ripple_path();
    t_full_carry();
    t_long_skip();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: got timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule